// File: doc/BRIEF.md
# Snooping Four-State Coherence Line Controller

This block keeps a small direct-mapped private cache coherent with the other caches that share one bus. Each line holds a tag, a one-word data payload and a two-bit coherence state: Invalid, Shared-Unmodified, Exclusive-Unmodified or Exclusive-Modified. The local processor issues reads and writes. Hits to exclusive lines complete without using the bus. Misses, upgrades of shared lines and write-backs are carried out as bus master transactions after an arbitration handshake.

At the same time the controller watches the address phases of the other bus masters. In the same cycle it reports whether it holds a valid copy, which drives the wired "shared" line. If the access touches a modified line, or a line that is still waiting in its write-back buffer, it raises an abort. The snooping logic then moves modified data into a single write-back buffer, requests the bus, and writes the data to memory. The aborted master retries afterwards and finds memory up to date.

The arbiter, the memory and the other caches are external. The bench models them.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: no snooped access sees a shared or abort indication, and no bus request is raised.
- R2: A read miss issues bus command 0 (read). The line fills as Shared-Unmodified if `bus_shared` is high in the address cycle, and as Exclusive-Unmodified otherwise. The fetched word is returned with `proc_ack`.
- R3: A read hit, or a write hit to an Exclusive line (modified or not), completes with no bus transaction. A write leaves the line Exclusive-Modified.
- R4: A write hit to a Shared-Unmodified line issues exactly one bus command 2 (invalidate), with no data phase, and leaves the line Exclusive-Modified.
- R5: `snp_shared` is high in the same cycle as a snooped read (command 0) whose address hits a valid line. A snooped read leaves a Shared line unchanged and moves an Exclusive-Unmodified line to Shared.
- R6: A snooped read that hits an Exclusive-Modified line raises `snp_abort` in that cycle. The line is then written back with bus command 3 (write-back) carrying its data, and it ends Shared-Unmodified.
- R7: A snooped read-with-intent-to-modify (command 1), or a snooped invalidate (command 2), that hits an unmodified line makes it Invalid without an abort.
- R8: A snooped command 1 that hits an Exclusive-Modified line raises `snp_abort`, writes the line back with command 3, and leaves it Invalid.
- R9: A pending upgrade whose Shared line is invalidated by a snooped command 2 before the grant is issued as command 1 instead of command 2.
- R10: A miss whose victim is Exclusive-Modified writes the victim back with command 3 before the refill. Any other victim is dropped with no bus traffic.
- R11: If `bus_retry` is high in the controller's address cycle, the controller reissues the same command until it is accepted, and then completes normally.
- R12: `bus_valid` is only high while `bus_gnt` is high. `bus_req` stays high from the address phase until the data phase ends. Command codes are 0 read, 1 read-with-intent-to-modify, 2 invalidate, 3 write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_req | input | 1 | Processor access request, held until acknowledged |
| proc_we | input | 1 | 1 = write, 0 = read |
| proc_addr | input | ADDR_W | Word address of the access |
| proc_wdata | input | DATA_W | Write data |
| proc_ack | output | 1 | One-cycle completion pulse |
| proc_rdata | output | DATA_W | Read data, valid with `proc_ack` |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Address phase of this master |
| bus_cmd | output | 2 | Command of the address phase |
| bus_addr | output | ADDR_W | Address of the address phase |
| bus_wdata | output | DATA_W | Write-back data |
| bus_retry | input | 1 | Another cache aborted this address phase |
| bus_shared | input | 1 | Wired-OR shared indication from other caches |
| bus_done | input | 1 | Data phase complete |
| bus_rdata | input | DATA_W | Data returned for a read |
| snp_valid | input | 1 | Another master's address phase |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy (combinational) |
| snp_abort | output | 1 | Abort the snooped transaction (combinational) |

## Verification
The bench targets the race in which an upgrade loses arbitration. A design that kept its stored invalidate would claim ownership without ever fetching the line, and the bench would see command 2 where command 1 is expected. It checks that a dirty victim's write-back comes before the refill and carries the right data. A controller that dropped the victim or fetched first would show one bus operation instead of two, or the wrong order. Snooped hits on modified lines are followed through the abort and the write-back to the final state. That final state is probed with later snoops, so a line left modified would abort again, and one left valid would still assert shared. Retried reads, and fills that choose between exclusive and shared, are confirmed by the command count and by whether a later write needs an invalidate.

// File: rtl/coh_line_pkg.sv
package coh_line_pkg;

    // Coherence state of a line (encoding is local to the block)
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    // Bus command codes shared with every master on the bus
    typedef enum logic [1:0] {
        CMD_RD    = 2'd0,
        CMD_RWITM = 2'd1,
        CMD_INV   = 2'd2,
        CMD_WB    = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'd0,
        FSM_ARB  = 2'd1,
        FSM_ADDR = 2'd2,
        FSM_DATA = 2'd3
    } fsm_e;

endpackage

// File: rtl/coh_tag_match.sv
module coh_tag_match
    import coh_line_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    input  line_st_e         line_st,
    output logic             hit
);
    always_comb begin
        hit = (line_st != ST_I) && (line_tag == req_tag);
    end
endmodule

// File: rtl/coh_snoop_policy.sv
module coh_snoop_policy
    import coh_line_pkg::*;
(
    input  logic     snp_valid,
    input  bus_cmd_e cmd,
    input  logic     hit,
    input  line_st_e line_st,
    input  logic     wb_match,
    input  logic     wb_busy,
    output logic     shared,
    output logic     abort,
    output logic     capture,
    output line_st_e nxt_st
);
    logic reads;
    logic dirty_hit;

    always_comb begin
        reads     = snp_valid && (cmd == CMD_RD || cmd == CMD_RWITM);
        dirty_hit = hit && (line_st == ST_M);
        shared    = snp_valid && (cmd == CMD_RD) && hit;
        abort     = reads && (dirty_hit || wb_match);
        capture   = reads && dirty_hit && !wb_busy;
        nxt_st    = line_st;
        if (snp_valid && hit) begin
            unique case (cmd)
                CMD_RD: begin
                    if (line_st == ST_E)               nxt_st = ST_S;
                    else if (line_st == ST_M && capture) nxt_st = ST_S;
                end
                CMD_RWITM: begin
                    if (line_st != ST_M)      nxt_st = ST_I;
                    else if (capture)         nxt_st = ST_I;
                end
                CMD_INV: begin
                    if (line_st != ST_M)      nxt_st = ST_I;
                end
                default: nxt_st = line_st;
            endcase
        end
    end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_line_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_req,
    input  logic              proc_we,
    input  logic [ADDR_W-1:0] proc_addr,
    input  logic [DATA_W-1:0] proc_wdata,
    output logic              proc_ack,
    output logic [DATA_W-1:0] proc_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_retry,
    input  logic              bus_shared,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_abort
);
    localparam int INDEX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int TAG_W   = ADDR_W - INDEX_W;

    typedef struct packed {
        fsm_e                          fsm;
        bus_cmd_e                      kind;
        logic                          shr;
        logic                          ack;
        logic [DATA_W-1:0]             rdata;
        logic                          wb_pend;
        logic [ADDR_W-1:0]             wb_addr;
        logic [DATA_W-1:0]             wb_data;
        logic [LINES-1:0][1:0]         st;
        logic [LINES-1:0][TAG_W-1:0]   tag;
        logic [LINES-1:0][DATA_W-1:0]  dat;
    } regs_t;

    regs_t r_q, r_d;

    logic [INDEX_W-1:0] l_idx, s_idx;
    logic [TAG_W-1:0]   l_tag, s_tag;
    line_st_e           l_st, s_st, s_nxt;
    logic               l_hit, s_hit, s_cap, wb_match;

    assign l_idx    = proc_addr[INDEX_W-1:0];
    assign l_tag    = proc_addr[ADDR_W-1:INDEX_W];
    assign s_idx    = snp_addr[INDEX_W-1:0];
    assign s_tag    = snp_addr[ADDR_W-1:INDEX_W];
    assign l_st     = line_st_e'(r_q.st[l_idx]);
    assign s_st     = line_st_e'(r_q.st[s_idx]);
    assign wb_match = r_q.wb_pend && (snp_addr == r_q.wb_addr);

    coh_tag_match #(.TAG_W(TAG_W)) u_lmatch (
        .line_tag (r_q.tag[l_idx]),
        .req_tag  (l_tag),
        .line_st  (l_st),
        .hit      (l_hit)
    );

    coh_tag_match #(.TAG_W(TAG_W)) u_smatch (
        .line_tag (r_q.tag[s_idx]),
        .req_tag  (s_tag),
        .line_st  (s_st),
        .hit      (s_hit)
    );

    coh_snoop_policy u_spol (
        .snp_valid (snp_valid),
        .cmd       (bus_cmd_e'(snp_cmd)),
        .hit       (s_hit),
        .line_st   (s_st),
        .wb_match  (wb_match),
        .wb_busy   (r_q.wb_pend),
        .shared    (snp_shared),
        .abort     (snp_abort),
        .capture   (s_cap),
        .nxt_st    (s_nxt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;

        // Snoop side: another master owns the bus
        if (snp_valid) begin
            r_d.st[s_idx] = s_nxt;
            if (s_cap) begin
                r_d.wb_pend = 1'b1;
                r_d.wb_addr = snp_addr;
                r_d.wb_data = r_q.dat[s_idx];
            end
        end

        unique case (r_q.fsm)
            FSM_IDLE: begin
                if (r_q.wb_pend) begin
                    r_d.fsm = FSM_ARB;
                end else if (proc_req && !r_q.ack && !snp_valid) begin
                    if (l_hit) begin
                        if (!proc_we) begin
                            r_d.ack   = 1'b1;
                            r_d.rdata = r_q.dat[l_idx];
                        end else if (l_st == ST_E || l_st == ST_M) begin
                            r_d.st[l_idx]  = ST_M;
                            r_d.dat[l_idx] = proc_wdata;
                            r_d.ack        = 1'b1;
                        end else begin
                            r_d.fsm = FSM_ARB;
                        end
                    end else begin
                        if (l_st == ST_M) begin
                            r_d.wb_pend   = 1'b1;
                            r_d.wb_addr   = {r_q.tag[l_idx], l_idx};
                            r_d.wb_data   = r_q.dat[l_idx];
                            r_d.st[l_idx] = ST_I;
                        end
                        r_d.fsm = FSM_ARB;
                    end
                end
            end
            FSM_ARB: begin
                if (bus_gnt) begin
                    r_d.fsm = FSM_ADDR;
                    if (r_q.wb_pend)                 r_d.kind = CMD_WB;
                    else if (!proc_we)               r_d.kind = CMD_RD;
                    else if (l_hit && l_st == ST_S)  r_d.kind = CMD_INV;
                    else                             r_d.kind = CMD_RWITM;
                end
            end
            FSM_ADDR: begin
                if (bus_retry) begin
                    r_d.fsm = FSM_ARB;
                end else begin
                    r_d.shr = bus_shared;
                    if (r_q.kind == CMD_INV) begin
                        r_d.st[l_idx]  = ST_M;
                        r_d.dat[l_idx] = proc_wdata;
                        r_d.ack        = 1'b1;
                        r_d.fsm        = FSM_IDLE;
                    end else begin
                        r_d.fsm = FSM_DATA;
                    end
                end
            end
            FSM_DATA: begin
                if (bus_done) begin
                    r_d.fsm = FSM_IDLE;
                    unique case (r_q.kind)
                        CMD_WB: r_d.wb_pend = 1'b0;
                        CMD_RD: begin
                            r_d.st[l_idx]  = r_q.shr ? ST_S : ST_E;
                            r_d.tag[l_idx] = l_tag;
                            r_d.dat[l_idx] = bus_rdata;
                            r_d.rdata      = bus_rdata;
                            r_d.ack        = 1'b1;
                        end
                        CMD_RWITM: begin
                            r_d.st[l_idx]  = ST_M;
                            r_d.tag[l_idx] = l_tag;
                            r_d.dat[l_idx] = proc_wdata;
                            r_d.ack        = 1'b1;
                        end
                        default: r_d.fsm = FSM_IDLE;
                    endcase
                end
            end
            default: r_d.fsm = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign proc_ack   = r_q.ack;
    assign proc_rdata = r_q.rdata;
    assign bus_req    = (r_q.fsm != FSM_IDLE);
    assign bus_valid  = (r_q.fsm == FSM_ADDR);
    assign bus_cmd    = r_q.kind;
    assign bus_addr   = (r_q.kind == CMD_WB) ? r_q.wb_addr : proc_addr;
    assign bus_wdata  = r_q.wb_data;

    // R12
    addr_phase_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_gnt);

    // R12
    bus_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_retry && bus_cmd != CMD_INV) |=> bus_req);

    // R5
    shared_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> (snp_valid && snp_cmd == CMD_RD));

    // R6
    abort_buffers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |=> r_q.wb_pend);

    // R8
    abort_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> (snp_valid && snp_cmd != CMD_INV && snp_cmd != CMD_WB));

    // R10
    wb_from_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == CMD_WB) |-> r_q.wb_pend);

endmodule

// File: tb/coh_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module coh_line_ctrl_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam logic [1:0] C_RD = 2'd0, C_RWITM = 2'd1, C_INV = 2'd2, C_WB = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic proc_req = 0, proc_we = 0, proc_ack;
    logic [AW-1:0] proc_addr = '0;
    logic [DW-1:0] proc_wdata = '0, proc_rdata;
    logic bus_req, bus_gnt = 0, bus_valid, bus_retry = 0, bus_shared = 0, bus_done = 0;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata = '0;
    logic snp_valid = 0, snp_shared, snp_abort;
    logic [1:0] snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;

    always #4 clk = ~clk;

    coh_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .proc_req(proc_req), .proc_we(proc_we), .proc_addr(proc_addr),
        .proc_wdata(proc_wdata), .proc_ack(proc_ack), .proc_rdata(proc_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_retry(bus_retry), .bus_shared(bus_shared), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
        .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_abort(snp_abort)
    );

    int checks = 0, errors = 0;
    logic [DW-1:0] mem [256];
    int nops;
    logic [1:0]    lcmd [8];
    logic [AW-1:0] laddr [8];
    logic [DW-1:0] ldata [8];
    logic done_next, got_ack, inv_pending, sh_resp;
    logic [DW-1:0] mem_rd, rd_cap;
    logic [AW-1:0] inv_addr;
    int retries_left;
    logic sh_o, ab_o;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_log();
        nops = 0;
    endtask

    // Arbiter, memory and peer-cache model, one step per falling edge
    task automatic run(input int ncyc, input bit until_ack);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            bus_done = 0; bus_retry = 0; bus_shared = 0; snp_valid = 0;
            if (done_next) begin
                bus_done = 1; bus_rdata = mem_rd; done_next = 0;
            end
            if (proc_ack && proc_req) begin
                got_ack = 1; rd_cap = proc_rdata; proc_req = 0;
            end
            if (bus_valid && !bus_gnt) chk("R12 valid without grant", 1, 0);
            if (inv_pending && bus_req && !bus_gnt) begin
                snp_valid = 1; snp_cmd = C_INV; snp_addr = inv_addr; inv_pending = 0;
            end else begin
                bus_gnt = bus_req;
                if (bus_valid) begin
                    if (nops < 8) begin
                        lcmd[nops] = bus_cmd; laddr[nops] = bus_addr; ldata[nops] = bus_wdata;
                    end
                    nops++;
                    if (retries_left > 0) begin
                        bus_retry = 1; retries_left--;
                    end else begin
                        bus_shared = sh_resp;
                        if (bus_cmd == C_WB) mem[bus_addr] = bus_wdata;
                        mem_rd = mem[bus_addr];
                        done_next = (bus_cmd != C_INV);
                    end
                end
            end
            if (until_ack && got_ack) break;
        end
    endtask

    task automatic op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic sh, input int retries, input logic inv_first, input string req);
        clr_log();
        got_ack = 0; sh_resp = sh; retries_left = retries;
        inv_pending = inv_first; inv_addr = a;
        @(negedge clk);
        proc_req = 1; proc_we = we; proc_addr = a; proc_wdata = wd;
        run(80, 1);
        chk({req, " ack"}, got_ack, 1);
        run(1, 0);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a);
        @(negedge clk);
        snp_valid = 1; snp_cmd = c; snp_addr = a;
        #1;
        sh_o = snp_shared; ab_o = snp_abort;
        @(negedge clk);
        snp_valid = 0;
    endtask

    task automatic drain_wb(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        clr_log(); sh_resp = 0; retries_left = 0; inv_pending = 0;
        run(12, 0);
        chk({req, " wb count"}, nops, 1);
        chk({req, " wb cmd"}, lcmd[0], C_WB);
        chk({req, " wb addr"}, laddr[0], a);
        chk({req, " wb data"}, ldata[0], d);
    endtask

    task automatic t_reset();
        chk("R1 bus_req", bus_req, 0);
        chk("R1 proc_ack", proc_ack, 0);
        snoop(C_RD, 8'h10);
        chk("R1 shared", sh_o, 0);
        chk("R1 abort", ab_o, 0);
    endtask

    task automatic t_exclusive_path();
        op(0, 8'h10, 0, 0, 0, 0, "R2");
        chk("R2 data", rd_cap, 16'hA010);
        chk("R2 cmd", lcmd[0], C_RD);
        op(1, 8'h10, 16'h1234, 0, 0, 0, "R3");
        chk("R3 no bus op", nops, 0);
        snoop(C_RD, 8'h10);
        chk("R6 abort", ab_o, 1);
        chk("R5 shared on dirty", sh_o, 1);
        drain_wb(8'h10, 16'h1234, "R6");
        snoop(C_RD, 8'h10);
        chk("R6 now shared no abort", ab_o, 0);
        chk("R6 now shared", sh_o, 1);
        snoop(C_RWITM, 8'h10);
        chk("R7 no abort", ab_o, 0);
        snoop(C_RD, 8'h10);
        chk("R7 invalid", sh_o, 0);
    endtask

    task automatic t_shared_path();
        op(0, 8'h21, 0, 1, 0, 0, "R2s");
        chk("R2 shared fill data", rd_cap, 16'hA021);
        op(1, 8'h21, 16'h5555, 0, 0, 0, "R4");
        chk("R4 one op", nops, 1);
        chk("R4 inv cmd", lcmd[0], C_INV);
        snoop(C_RWITM, 8'h21);
        chk("R8 abort", ab_o, 1);
        drain_wb(8'h21, 16'h5555, "R8");
        snoop(C_RD, 8'h21);
        chk("R8 invalid shared", sh_o, 0);
        chk("R8 invalid abort", ab_o, 0);
    endtask

    task automatic t_upgrade_race();
        op(0, 8'h05, 0, 1, 0, 0, "R9 fill");
        op(1, 8'h05, 16'h7777, 0, 0, 1, "R9");
        chk("R9 one op", nops, 1);
        chk("R9 converted", lcmd[0], C_RWITM);
        snoop(C_RD, 8'h05);
        chk("R9 owner after", ab_o, 1);
        drain_wb(8'h05, 16'h7777, "R9");
    endtask

    task automatic t_evict();
        op(1, 8'h12, 16'hBEEF, 0, 0, 0, "R10 own");
        chk("R10 rwitm", lcmd[0], C_RWITM);
        op(0, 8'h32, 0, 0, 0, 0, "R10 dirty");
        chk("R10 two ops", nops, 2);
        chk("R10 wb first", lcmd[0], C_WB);
        chk("R10 wb addr", laddr[0], 8'h12);
        chk("R10 wb data", ldata[0], 16'hBEEF);
        chk("R10 refill", lcmd[1], C_RD);
        chk("R10 data", rd_cap, 16'hA032);
        op(0, 8'h42, 0, 0, 0, 0, "R10 clean");
        chk("R10 silent", nops, 1);
        chk("R10 clean data", rd_cap, 16'hA042);
    endtask

    task automatic t_retry();
        op(0, 8'h33, 0, 0, 2, 0, "R11");
        chk("R11 attempts", nops, 3);
        chk("R11 same cmd", lcmd[2], C_RD);
        chk("R11 same addr", laddr[1], 8'h33);
        chk("R11 data", rd_cap, 16'hA033);
    endtask

    task automatic t_snoop_exclusive();
        snoop(C_RD, 8'h33);
        chk("R5 E shared", sh_o, 1);
        chk("R5 E no abort", ab_o, 0);
        snoop(C_RD, 8'h33);
        chk("R5 S unchanged", sh_o, 1);
        op(1, 8'h33, 16'h4242, 0, 0, 0, "R5 upgrade");
        chk("R5 needs inv", lcmd[0], C_INV);
        op(0, 8'h33, 0, 0, 0, 0, "R3 hit");
        chk("R3 hit no op", nops, 0);
        chk("R3 hit data", rd_cap, 16'h4242);
        snoop(C_RD, 8'h13);
        chk("R5 tag miss", sh_o, 0);
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 16'hA000 | 16'(a);
        done_next = 0; got_ack = 0; inv_pending = 0; sh_resp = 0;
        retries_left = 0; nops = 0; mem_rd = '0; rd_cap = '0; inv_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_exclusive_path();
        t_shared_path();
        t_upgrade_race();
        t_evict();
        t_retry();
        t_snoop_exclusive();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule